// File: doc/BRIEF.md
# UART Interrupt and FIFO-Level Controller

This block collects every interrupt source of a UART into one status word, applies a per-bit enable mask, and drives a single combined interrupt line. Nine sources arrive as one-cycle event pulses: four modem-line changes, a receive timeout, and four receive errors. The other two, the transmit and receive FIFO-level interrupts, are made inside the block by comparing the fill levels of the two 16-entry FIFOs against thresholds chosen by 3-bit fraction codes.

Each FIFO has its own small two-state machine. State `LV_OUTSIDE` means the fill level is not in the interrupt region. State `LV_INSIDE` means it is. The transition `enter` (OUTSIDE to INSIDE) happens on the clock edge where the level is found inside the region, and it emits a one-cycle hit that sets the raw bit. The transition `leave` (INSIDE to OUTSIDE) happens when the level is found outside the region, and it re-arms the machine. Software clears raw bits by writing ones to a clear strobe. The same status also gates the receive DMA request: when error gating is on, the request is held off while any enabled error bit is pending.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit positions are: 0 ring, 1 clear-to-send change, 2 carrier-detect change, 3 data-set-ready change, 4 receive level, 5 transmit level, 6 receive timeout, 7 framing error, 8 parity error, 9 break error, 10 overrun. An event pulse held high for one cycle sets its bit at the next rising clock edge.
- R2: `mask_we` loads `mask_wdata` into the mask at the next edge. `mask_stat` equals `raw_stat` AND mask, and the mask resets to zero.
- R3: With `clr_we` high, each 1 in `clr_wdata` clears the matching raw bit at the next edge. Each 0 leaves its bit unchanged.
- R4: When a set event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: Transmit code `tx_sel` values 0..4 give thresholds of 2, 4, 8, 12 and 14 entries; codes 5..7 give 8. Bit 5 sets one edge after `tx_level` moves from above the threshold to at or below it.
- R6: Receive code `rx_sel` uses the same mapping. Bit 4 sets one edge after `rx_level` moves from below the threshold to at or above it.
- R7: The level interrupts are edge-triggered. Once cleared, a level bit stays clear while the level remains in its region. It sets again only after the level leaves the region and re-enters it.
- R8: `irq` is high exactly when some bit of `mask_stat` is high.
- R9: `tx_dma_ok` follows `tx_dma_en`. `rx_dma_ok` equals `rx_dma_en` AND NOT (`dma_err_gate` AND any of `mask_stat[10:7]`).
- R10: While `rst_n` is low, `raw_stat`, `mask_stat` and `irq` are zero, and both level machines are in `LV_OUTSIDE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 5 | Transmit FIFO fill level, 0..16 |
| rx_level | input | 5 | Receive FIFO fill level, 0..16 |
| tx_sel | input | 3 | Transmit threshold fraction code |
| rx_sel | input | 3 | Receive threshold fraction code |
| ev_modem | input | 4 | Modem change pulses: bit0 ring, bit1 CTS, bit2 DCD, bit3 DSR |
| ev_rx_tmo | input | 1 | Receive timeout pulse |
| ev_err | input | 4 | Error pulses: bit0 framing, bit1 parity, bit2 break, bit3 overrun |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | Mask write value |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 11 | Bits to clear (1 clears) |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| dma_err_gate | input | 1 | Suppress receive DMA while an error interrupt is pending |
| raw_stat | output | 11 | Raw interrupt status |
| mask_stat | output | 11 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |
| rx_dma_ok | output | 1 | Receive DMA request enable |
| tx_dma_ok | output | 1 | Transmit DMA request enable |

## Verification
Any state error in a level machine shows up on `raw_stat` one edge after a level change. A machine stuck in `LV_INSIDE` misses a crossing. A machine stuck in `LV_OUTSIDE` sets its bit again right after a clear. The bench sweeps every threshold code against every fill level from 0 to 16, in both directions, so a wrong threshold or comparison fails within a single step. A corrupted status or mask register appears on `mask_stat`, `irq` and `rx_dma_ok` in the same cycle it holds, because these outputs are combinational from the registers.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

    localparam int IRQ_N = 11;

    // Status bit positions
    localparam int IX_RI  = 0;
    localparam int IX_CTS = 1;
    localparam int IX_DCD = 2;
    localparam int IX_DSR = 3;
    localparam int IX_RX  = 4;
    localparam int IX_TX  = 5;
    localparam int IX_RT  = 6;
    localparam int IX_FE  = 7;
    localparam int IX_PE  = 8;
    localparam int IX_BE  = 9;
    localparam int IX_OE  = 10;

    typedef enum logic {
        LV_OUTSIDE = 1'b0,
        LV_INSIDE  = 1'b1
    } lvl_state_e;

    // Fraction of the FIFO depth, expressed in eighths
    function automatic int unsigned frac_eighths(input logic [2:0] code);
        int unsigned e;
        unique case (code)
            3'd0:    e = 1;
            3'd1:    e = 2;
            3'd2:    e = 4;
            3'd3:    e = 6;
            3'd4:    e = 7;
            default: e = 4;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/uart_irq_level_fsm.sv
`timescale 1ns/1ps
module uart_irq_level_fsm
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [2:0]       sel,
    output logic             hit
);

    lvl_state_e       state_q, state_d;
    logic [LVL_W-1:0] thr;
    logic             in_region;

    always_comb begin
        thr = LVL_W'((DEPTH * frac_eighths(sel)) / 8);
    end

    // Receive side fires on rising fill, transmit side on draining fill
    generate
        if (IS_RX) begin : g_fill
            always_comb in_region = (level >= thr);
        end else begin : g_drain
            always_comb in_region = (level <= thr);
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LV_OUTSIDE;
        else        state_q <= state_d;
    end

    // Next state: enter / leave
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_OUTSIDE: if (in_region)  state_d = LV_INSIDE;
            LV_INSIDE:  if (!in_region) state_d = LV_OUTSIDE;
            default:    state_d = LV_OUTSIDE;
        endcase
    end

    // Output: single-cycle hit on the enter transition
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            LV_OUTSIDE: hit = in_region;
            LV_INSIDE:  hit = 1'b0;
            default:    hit = 1'b0;
        endcase
    end

    // R7: a crossing yields exactly one hit
    p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R7: staying in region after entry never re-fires
    p_quiet_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_INSIDE && in_region) |=> !hit);

endmodule

// File: rtl/uart_irq_status_bank.sv
`timescale 1ns/1ps
module uart_irq_status_bank #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [N-1:0] mask_vec,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o
);

    logic [N-1:0] raw_q, mask_q, kill;

    always_comb kill = clr_we ? clr_vec : '0;

    // Set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~kill) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_vec;
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && set_vec == '0) |=> $stable(raw_q));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_vec)));

endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [2:0]       tx_sel,
    input  logic [2:0]       rx_sel,
    input  logic [3:0]       ev_modem,
    input  logic             ev_rx_tmo,
    input  logic [3:0]       ev_err,
    input  logic             mask_we,
    input  logic [IRQ_N-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [IRQ_N-1:0] clr_wdata,
    input  logic             rx_dma_en,
    input  logic             tx_dma_en,
    input  logic             dma_err_gate,
    output logic [IRQ_N-1:0] raw_stat,
    output logic [IRQ_N-1:0] mask_stat,
    output logic             irq,
    output logic             rx_dma_ok,
    output logic             tx_dma_ok
);

    // Index 0 = transmit, 1 = receive
    logic [1:0][LVL_W-1:0] lvl;
    logic [1:0][2:0]       sel;
    logic [1:0]            hit;
    logic [IRQ_N-1:0]      set_vec, mask_q;
    logic                  err_pending;

    assign lvl = {rx_level, tx_level};
    assign sel = {rx_sel, tx_sel};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lvl
            uart_irq_level_fsm #(
                .DEPTH (DEPTH),
                .IS_RX (g == 1)
            ) u_fsm (
                .clk   (clk),
                .rst_n (rst_n),
                .level (lvl[g]),
                .sel   (sel[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    always_comb begin
        set_vec           = '0;
        set_vec[IX_RI]    = ev_modem[0];
        set_vec[IX_CTS]   = ev_modem[1];
        set_vec[IX_DCD]   = ev_modem[2];
        set_vec[IX_DSR]   = ev_modem[3];
        set_vec[IX_RX]    = hit[1];
        set_vec[IX_TX]    = hit[0];
        set_vec[IX_RT]    = ev_rx_tmo;
        set_vec[IX_FE]    = ev_err[0];
        set_vec[IX_PE]    = ev_err[1];
        set_vec[IX_BE]    = ev_err[2];
        set_vec[IX_OE]    = ev_err[3];
    end

    uart_irq_status_bank #(.N(IRQ_N)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_vec  (clr_wdata),
        .mask_we  (mask_we),
        .mask_vec (mask_wdata),
        .raw_o    (raw_stat),
        .mask_o   (mask_q)
    );

    always_comb begin
        mask_stat   = raw_stat & mask_q;
        irq         = |mask_stat;
        err_pending = |mask_stat[IX_OE:IX_FE];
        rx_dma_ok   = rx_dma_en & ~(dma_err_gate & err_pending);
        tx_dma_ok   = tx_dma_en;
    end

    p_tx_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> raw_stat[IX_TX]);

    p_rx_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> raw_stat[IX_RX]);

    p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat == '0) |-> !irq);

    p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_err_gate && (raw_stat[IX_FE] && mask_q[IX_FE])) |-> !rx_dma_ok);

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (raw_stat == '0 || $isunknown(raw_stat));
        end
    end

endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;

    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [LW-1:0] tx_level, rx_level;
    logic [2:0]    tx_sel, rx_sel;
    logic [3:0]    ev_modem, ev_err;
    logic          ev_rx_tmo, mask_we, clr_we;
    logic [10:0]   mask_wdata, clr_wdata;
    logic          rx_dma_en, tx_dma_en, dma_err_gate;
    logic [10:0]   raw_stat, mask_stat;
    logic          irq, rx_dma_ok, tx_dma_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_sel(tx_sel), .rx_sel(rx_sel),
        .ev_modem(ev_modem), .ev_rx_tmo(ev_rx_tmo), .ev_err(ev_err),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .dma_err_gate(dma_err_gate),
        .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq),
        .rx_dma_ok(rx_dma_ok), .tx_dma_ok(tx_dma_ok)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int thr_of(input int code);
        int e;
        case (code)
            0: e = 1;
            1: e = 2;
            2: e = 4;
            3: e = 6;
            4: e = 7;
            default: e = 4;
        endcase
        return DEPTH * e / 8;
    endfunction

    task automatic clear_bits(input logic [10:0] m);
        clr_we = 1'b1; clr_wdata = m;
        tick();
        clr_we = 1'b0; clr_wdata = '0;
    endtask

    task automatic write_mask(input logic [10:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick();
        mask_we = 1'b0;
    endtask

    // Pulse events: bits of v in status order (level bits 4,5 ignored)
    task automatic pulse(input logic [10:0] v);
        ev_modem  = v[3:0];
        ev_rx_tmo = v[6];
        ev_err    = v[10:7];
        tick();
        ev_modem = '0; ev_rx_tmo = 1'b0; ev_err = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        tx_level = LW'(DEPTH); rx_level = '0;
        tx_sel = '0; rx_sel = '0;
        ev_modem = '0; ev_err = '0; ev_rx_tmo = 1'b0;
        mask_we = 1'b0; mask_wdata = '0; clr_we = 1'b0; clr_wdata = '0;
        rx_dma_en = 1'b0; tx_dma_en = 1'b0; dma_err_gate = 1'b0;
        tick(); tick();
        // R10: reset state, with events asserted during reset
        ev_err = 4'hF; ev_modem = 4'hF;
        tick();
        check("R10 raw in reset", raw_stat, 0);
        check("R10 masked in reset", mask_stat, 0);
        check("R10 irq in reset", irq, 0);
        ev_err = '0; ev_modem = '0;
        rst_n = 1'b1;
        tick(); tick();
        check("R10 quiet after reset, levels outside", raw_stat, 0);

        // R1: each event pulse sets only its own bit
        foreach (ev_err[k]) begin end
        for (int i = 0; i < 11; i++) begin
            if (i == 4 || i == 5) continue;
            pulse(11'(1) << i);
            check($sformatf("R1 event bit %0d", i), raw_stat, 32'(11'(1) << i));
            clear_bits('1);
        end

        // R5 / R6: sweep every code and level in both directions
        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                tx_sel = 3'(s); rx_sel = 3'(s);
                tx_level = LW'(DEPTH); rx_level = '0;
                tick();
                clear_bits(11'h030);
                tx_level = LW'(l); rx_level = LW'(l);
                tick();
                check($sformatf("R5 tx code %0d level %0d", s, l), raw_stat[5], (l <= thr_of(s)));
                check($sformatf("R6 rx code %0d level %0d", s, l), raw_stat[4], (l >= thr_of(s)));
            end
        end
        tx_level = LW'(DEPTH); rx_level = '0;
        tick();
        clear_bits('1);

        // R7: edge behaviour, transmit (thr 8) and receive (thr 12)
        tx_sel = 3'd2; rx_sel = 3'd3;
        tx_level = 5'd5; tick();
        check("R7 tx fires on entry", raw_stat[5], 1);
        clear_bits(11'h020);
        tx_level = 5'd3; tick(); tick();
        check("R7 tx stays clear inside", raw_stat[5], 0);
        tx_level = 5'd10; tick();
        check("R7 tx clear while outside", raw_stat[5], 0);
        tx_level = 5'd8; tick();
        check("R7 tx refires on re-entry", raw_stat[5], 1);
        rx_level = 5'd13; tick();
        check("R7 rx fires on entry", raw_stat[4], 1);
        clear_bits(11'h010);
        rx_level = 5'd16; tick();
        check("R7 rx stays clear inside", raw_stat[4], 0);
        rx_level = 5'd11; tick(); rx_level = 5'd12; tick();
        check("R7 rx refires on re-entry", raw_stat[4], 1);
        tx_level = LW'(DEPTH); rx_level = '0; tick();
        clear_bits('1);

        // R2 / R8: mask sweep over a fixed raw pattern
        pulse(11'h7CF);
        check("R1 all events", raw_stat, 32'h7CF);
        begin
            logic [10:0] pats [6] = '{11'h000, 11'h7FF, 11'h155, 11'h2AA, 11'h030, 11'h40F};
            foreach (pats[p]) begin
                write_mask(pats[p]);
                check($sformatf("R2 mask %0h", pats[p]), mask_stat, 32'(11'h7CF & pats[p]));
                check($sformatf("R8 irq mask %0h", pats[p]), irq, 32'(|(11'h7CF & pats[p])));
            end
        end

        // R3: clear ones only; zeros ignored
        clear_bits(11'h005);
        check("R3 partial clear", raw_stat, 32'h7CA);
        clear_bits(11'h000);
        check("R3 zero clear ignored", raw_stat, 32'h7CA);

        // R4: set beats clear in the same cycle
        clr_we = 1'b1; clr_wdata = 11'h7FF;
        ev_err = 4'b0001; ev_modem = 4'b0010;
        tick();
        clr_we = 1'b0; clr_wdata = '0; ev_err = '0; ev_modem = '0;
        check("R4 set wins", raw_stat, 32'h082);
        clear_bits('1);

        // R9: DMA gating over enables, gate, error pending, error mask
        for (int e = 0; e < 2; e++) begin
            for (int mk = 0; mk < 2; mk++) begin
                clear_bits('1);
                write_mask(mk ? 11'h780 : 11'h000);
                if (e) pulse(11'h080);
                for (int c = 0; c < 8; c++) begin
                    rx_dma_en = c[0]; tx_dma_en = c[1]; dma_err_gate = c[2];
                    #1;
                    check($sformatf("R9 rx e%0d m%0d c%0d", e, mk, c), rx_dma_ok,
                          c[0] & ~(c[2] & e[0] & mk[0]));
                    check($sformatf("R9 tx c%0d", c), tx_dma_ok, c[1]);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule